// File: doc/BRIEF.md
# Link Input Status Capture with Sticky Interrupt

This block sits behind the deserializer of a codec audio link. It watches the twelfth input slot of every incoming frame, which carries the state of the codec's general-purpose input pins. Each time the deserializer presents that slot with a strobe, the block keeps the top sixteen bits as the current pin status. Software reads that status from local storage, so a read never starts a transaction on the link.

Each pin has two mask bits that software writes. The sticky-enable bit lets a rising change on that pin set a per-pin flag. The flag stays set until software writes a one to its clear bit. The interrupt-enable bit lets a set flag drive the single interrupt line. The line is a level and stays asserted across any number of frames until software clears the flags behind it.

Top module: `gpi_status_capture`

## Requirements
- R1: When `slot_valid` is high at a rising clock edge, `gpi_status` takes bits [19:4] of `slot_data` (the sixteen most significant bits) on that edge.
- R2: Bits [3:0] of `slot_data` have no effect on `gpi_status`, the flags or the interrupt.
- R3: While `slot_valid` is low, `gpi_status` holds its value, so reads are served from local storage.
- R4: A flag bit sets on the edge where a valid slot makes its status bit go from 0 to 1, and only if that pin's sticky-enable bit is 1. A status bit that stays at 1, or that falls, sets nothing.
- R5: A set flag bit holds until `clr_we` is high with a 1 in that bit of `clr_data`. Zero bits in `clr_data` leave their flags unchanged.
- R6: `irq` is high exactly when some pin has its flag, its sticky-enable bit and its interrupt-enable bit all at 1. With the default `IRQ_REG` = 0 the line follows these registers with no extra delay.
- R7: `irq` stays high over later frames, including frames where the status bit falls, until the flag is cleared or a mask bit is removed.
- R8: If a clear and a set event hit the same flag bit on the same edge, the flag ends up set.
- R9: Reset (`rst_n` low) sets the status, the flags and both mask registers to zero, so `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | Strobe: `slot_data` holds this frame's status slot |
| slot_data | input | 20 | Status slot word from the deserializer |
| sten_we | input | 1 | Write strobe for the sticky-enable mask |
| sten_data | input | 16 | New sticky-enable mask |
| inten_we | input | 1 | Write strobe for the interrupt-enable mask |
| inten_data | input | 16 | New interrupt-enable mask |
| clr_we | input | 1 | Write strobe for the write-one-to-clear flag port |
| clr_data | input | 16 | Flag bits to clear (1 = clear) |
| gpi_status | output | 16 | Status captured from the most recent slot |
| gpi_flags | output | 16 | Per-pin sticky flags |
| irq | output | 1 | Level interrupt |

## Verification
Slot words are sent whose upper bits differ while the low nibble changes and does not change. This separates a correct field slice from one that is shifted or too wide. Frames drive pins through rising, steady-high and falling patterns, first with sticky-enable cleared and then with it set. This shows whether the flag follows a true edge or the level. The interrupt is tried with each mask bit removed in turn, and over frames where the pin falls again, to tell a gated, held level from a pulse. A clear that lands on the same edge as a new rise checks which of the two wins.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
   localparam int unsigned GPI_W_DEF  = 16;
   localparam int unsigned SLOT_W_DEF = 20;

   typedef enum logic {
      IRQ_COMB = 1'b0,
      IRQ_FLOP = 1'b1
   } irq_mode_e;
endpackage

// File: rtl/gpi_capture.sv
module gpi_capture #(
   parameter int unsigned SLOT_W = 20,
   parameter int unsigned GPI_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_valid,
   input  logic [SLOT_W-1:0] slot_data,
   output logic [GPI_W-1:0]  status_q,
   output logic [GPI_W-1:0]  rise_vec
);
   localparam int unsigned LOW_W = SLOT_W - GPI_W;

   logic [GPI_W-1:0] field;

   generate
      if (GPI_W == 0 || SLOT_W < GPI_W) begin : g_bad
         $error("gpi_capture: status field does not fit the slot");
      end
   endgenerate

   assign field    = slot_data[SLOT_W-1:LOW_W];
   assign rise_vec = slot_valid ? (field & ~status_q) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
      end else if (slot_valid) begin
         status_q <= field;
      end
   end
endmodule

// File: rtl/gpi_sticky_bank.sv
module gpi_sticky_bank #(
   parameter int unsigned GPI_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GPI_W-1:0] rise_vec,
   input  logic [GPI_W-1:0] sten_q,
   input  logic             clr_we,
   input  logic [GPI_W-1:0] clr_data,
   output logic [GPI_W-1:0] flags_q
);
   generate
      for (genvar i = 0; i < GPI_W; i++) begin : g_pin
         logic set_i;
         logic clr_i;
         assign set_i = rise_vec[i] & sten_q[i];
         assign clr_i = clr_we & clr_data[i];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flags_q[i] <= 1'b0;
            end else if (set_i) begin
               flags_q[i] <= 1'b1;
            end else if (clr_i) begin
               flags_q[i] <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/gpi_irq_tree.sv
module gpi_irq_tree #(
   parameter int unsigned GPI_W   = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GPI_W-1:0] flags_q,
   input  logic [GPI_W-1:0] sten_q,
   input  logic [GPI_W-1:0] inten_q,
   output logic             irq
);
   logic [GPI_W-1:0] armed;
   logic             any_armed;

   assign armed     = flags_q & sten_q & inten_q;
   assign any_armed = |armed;

   generate
      if (IRQ_REG == gpi_pkg::IRQ_FLOP) begin : g_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_armed;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = any_armed;
      end
   endgenerate
endmodule

// File: rtl/gpi_status_capture.sv
module gpi_status_capture #(
   parameter int unsigned SLOT_W  = gpi_pkg::SLOT_W_DEF,
   parameter int unsigned GPI_W   = gpi_pkg::GPI_W_DEF,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_valid,
   input  logic [SLOT_W-1:0] slot_data,
   input  logic              sten_we,
   input  logic [GPI_W-1:0]  sten_data,
   input  logic              inten_we,
   input  logic [GPI_W-1:0]  inten_data,
   input  logic              clr_we,
   input  logic [GPI_W-1:0]  clr_data,
   output logic [GPI_W-1:0]  gpi_status,
   output logic [GPI_W-1:0]  gpi_flags,
   output logic              irq
);
   logic [GPI_W-1:0] sten_q;
   logic [GPI_W-1:0] inten_q;
   logic [GPI_W-1:0] rise_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sten_q  <= '0;
         inten_q <= '0;
      end else begin
         if (sten_we)  sten_q  <= sten_data;
         if (inten_we) inten_q <= inten_data;
      end
   end

   gpi_capture #(.SLOT_W(SLOT_W), .GPI_W(GPI_W)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_valid (slot_valid),
      .slot_data  (slot_data),
      .status_q   (gpi_status),
      .rise_vec   (rise_vec)
   );

   gpi_sticky_bank #(.GPI_W(GPI_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_vec (rise_vec),
      .sten_q   (sten_q),
      .clr_we   (clr_we),
      .clr_data (clr_data),
      .flags_q  (gpi_flags)
   );

   gpi_irq_tree #(.GPI_W(GPI_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_q (gpi_flags),
      .sten_q  (sten_q),
      .inten_q (inten_q),
      .irq     (irq)
   );
endmodule

// File: rtl/gpi_status_capture_chk.sv
module gpi_status_capture_chk #(
   parameter int unsigned SLOT_W  = 20,
   parameter int unsigned GPI_W   = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              slot_valid,
   input logic [SLOT_W-1:0] slot_data,
   input logic              clr_we,
   input logic [GPI_W-1:0]  clr_data,
   input logic [GPI_W-1:0]  gpi_status,
   input logic [GPI_W-1:0]  gpi_flags,
   input logic [GPI_W-1:0]  sten_q,
   input logic [GPI_W-1:0]  inten_q,
   input logic [GPI_W-1:0]  rise_vec,
   input logic              irq
);
   localparam int unsigned LOW_W = SLOT_W - GPI_W;

   logic [GPI_W-1:0] clr_mask;
   assign clr_mask = clr_we ? clr_data : '0;

   p_status_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid |=> gpi_status == $past(slot_data[SLOT_W-1:LOW_W]));

   p_status_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_valid |=> $stable(gpi_status));

   p_flag_persist_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(gpi_flags & ~clr_mask) & ~gpi_flags) == '0));

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(rise_vec & sten_q) & ~gpi_flags) == '0));

   generate
      if (IRQ_REG) begin : g_flop
         p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> irq == ($past(gpi_flags & sten_q & inten_q) != '0));
      end else begin : g_comb
         p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq == ((gpi_flags & sten_q & inten_q) != '0));
      end
   endgenerate
endmodule

bind gpi_status_capture gpi_status_capture_chk #(
   .SLOT_W(SLOT_W), .GPI_W(GPI_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slot_valid (slot_valid),
   .slot_data  (slot_data),
   .clr_we     (clr_we),
   .clr_data   (clr_data),
   .gpi_status (gpi_status),
   .gpi_flags  (gpi_flags),
   .sten_q     (sten_q),
   .inten_q    (inten_q),
   .rise_vec   (rise_vec),
   .irq        (irq)
);

// File: tb/gpi_status_capture_tb.sv
module gpi_status_capture_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slot_valid = 1'b0;
   logic [19:0] slot_data = '0;
   logic        sten_we = 1'b0;
   logic [15:0] sten_data = '0;
   logic        inten_we = 1'b0;
   logic [15:0] inten_data = '0;
   logic        clr_we = 1'b0;
   logic [15:0] clr_data = '0;
   logic [15:0] gpi_status;
   logic [15:0] gpi_flags;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   gpi_status_capture u_dut (
      .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_data(slot_data),
      .sten_we(sten_we), .sten_data(sten_data), .inten_we(inten_we),
      .inten_data(inten_data), .clr_we(clr_we), .clr_data(clr_data),
      .gpi_status(gpi_status), .gpi_flags(gpi_flags), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic frame(input logic [19:0] d);
      slot_valid = 1'b1; slot_data = d;
      @(negedge clk);
      slot_valid = 1'b0; slot_data = '0;
   endtask

   task automatic frame_clr(input logic [19:0] d, input logic [15:0] c);
      slot_valid = 1'b1; slot_data = d; clr_we = 1'b1; clr_data = c;
      @(negedge clk);
      slot_valid = 1'b0; slot_data = '0; clr_we = 1'b0; clr_data = '0;
   endtask

   task automatic set_sten(input logic [15:0] v);
      sten_we = 1'b1; sten_data = v;
      @(negedge clk);
      sten_we = 1'b0;
   endtask

   task automatic set_inten(input logic [15:0] v);
      inten_we = 1'b1; inten_data = v;
      @(negedge clk);
      inten_we = 1'b0;
   endtask

   task automatic clear(input logic [15:0] v);
      clr_we = 1'b1; clr_data = v;
      @(negedge clk);
      clr_we = 1'b0; clr_data = '0;
   endtask

   task automatic t_reset;
      chk("R9 status", gpi_status, 0);
      chk("R9 flags", gpi_flags, 0);
      chk("R9 irq", irq, 0);
   endtask

   task automatic t_capture;
      frame(20'hABCDE);
      chk("R1 capture", gpi_status, 16'hABCD);
      frame(20'h1234F);
      chk("R1 capture 2", gpi_status, 16'h1234);
      frame(20'h12340);
      chk("R2 low nibble ignored", gpi_status, 16'h1234);
      chk("R4 no flags with sticky off", gpi_flags, 0);
   endtask

   task automatic t_hold;
      slot_data = 20'hFFFFF;
      repeat (5) @(negedge clk);
      slot_data = '0;
      chk("R3 hold without strobe", gpi_status, 16'h1234);
   endtask

   task automatic t_sticky_irq;
      set_sten(16'hFFFF);
      frame(20'h00000);
      chk("R4 falling sets nothing", gpi_flags, 0);
      frame(20'h0005F);
      chk("R4 rise sets flags", gpi_flags, 16'h0005);
      chk("R2 nibble adds no flag", gpi_flags, 16'h0005);
      chk("R6 no irq without int enable", irq, 0);
      set_inten(16'h0004);
      chk("R6 irq when both set", irq, 1);
      frame(20'h00000);
      chk("R7 irq held after pin falls", irq, 1);
      chk("R7 flags held", gpi_flags, 16'h0005);
      frame(20'h00000);
      chk("R7 irq held next frame", irq, 1);
      clear(16'h0004);
      chk("R5 w1c clears bit", gpi_flags, 16'h0001);
      chk("R6 irq drops", irq, 0);
      clear(16'h0000);
      chk("R5 zero clear no effect", gpi_flags, 16'h0001);
      set_sten(16'hFFFE);
      set_inten(16'h0001);
      chk("R6 gated by sticky enable", irq, 0);
      set_sten(16'hFFFF);
      chk("R6 irq with both bits", irq, 1);
      clear(16'h0001);
      chk("R5 all cleared", gpi_flags, 0);
      chk("R6 irq low after clear", irq, 0);
   endtask

   task automatic t_set_wins;
      frame_clr(20'h00080, 16'h0008);
      chk("R8 set wins over clear", gpi_flags, 16'h0008);
      clear(16'h0008);
      frame(20'h00080);
      chk("R4 steady high sets nothing", gpi_flags, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_capture();
            t_hold();
            t_sticky_irq();
            t_set_wins();
         end
         begin
            repeat (20000) @(negedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule